// File: doc/BRIEF.md
# Triggered Two-Channel Acquisition Sequencer

This block paces the sampling of two analog channels, a detector array signal and a reference detector signal, against three timing inputs from the sensor: a start pulse, an end-of-scan pulse and a scan-clock trigger. Software-side setup is reduced to one arm command. The arm command loads the number of scans to keep. After arming, the block waits for a start pulse before it converts anything. From then on every trigger produces a pair of conversions. Pairs that start before the first end-of-scan pulse fill a holding slot that the next pair overwrites, and they never reach the output. This hides the pixel that can be lost while the external timebase settles.

After the end-of-scan pulse, each trigger produces one saved pair. The array channel is converted first and the reference channel second. The block then presents the two results together with a one-cycle valid strobe. The conversion strobe comes from a down-counting pulse generator. Its high and low phase lengths are set independently, so each conversion gets a settling window matched to the converter. When the requested number of pairs has been saved, the block raises done and ignores further triggers until it is armed again. A trigger that arrives while a pair is still in progress sets a sticky overrun flag.

Top module: `acq_seq_top`

## Requirements
- R1: A one-cycle `armReq` loads `scanCount`, clears `overrun` in the following cycle and returns the sequencer to waiting for a start pulse. Until a rising edge of `stIn` is seen after the arm, rising edges of `trigIn` and `eosIn` cause no conversion strobe.
- R2: After the start pulse and before the first end-of-scan pulse, each accepted trigger still runs a full conversion pair, but `pairValid` stays low for that pair.
- R3: The first rising edge of `eosIn` after the start pulse switches the block to saving. A pair is saved or discarded according to the phase in force when its trigger was accepted. `pairValid` never asserts unless an end-of-scan edge has followed the start edge since the last arm.
- R4: Each accepted trigger produces exactly two rising edges of `convStrobe`. The first carries `convSel` = 0 (array channel) and the second carries `convSel` = 1 (reference channel). `convSel` holds steady while `convStrobe` is high.
- R5: Each strobe period is high for `phaseHigh` cycles, then low for `phaseLow` cycles. A value of 0 counts as 1. Both values are captured when the trigger is accepted. The first strobe follows the trigger edge by one cycle.
- R6: An ADC result presented with `adcValid` is assigned to the channel of the most recent strobe. One cycle after the reference result of a saved pair, `pairValid` pulses for one cycle with `pairArray` and `pairRef` holding the two 12-bit results.
- R7: Every saved pair lowers the remaining count by one. When the count reaches zero and the strobe train is idle, `done` asserts. After that, triggers produce no strobe and no output until the next arm.
- R8: Arming with `scanCount` = 0 raises `done` in the cycle after the arm.
- R9: A trigger edge while a pair is in progress sets `overrun`. The flag stays set until the next arm, and the trigger adds no strobe.
- R10: An arm during a pair abandons it: `convStrobe` is low from the next cycle on and the pair is not output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armReq | input | 1 | One-cycle arm command |
| scanCount | input | CNT_W | Number of pairs to save, loaded at arm |
| phaseHigh | input | PH_W | Strobe high-phase length in cycles |
| phaseLow | input | PH_W | Strobe low-phase length in cycles |
| stIn | input | 1 | Start pulse (post-trigger), rising-edge sensitive |
| eosIn | input | 1 | End-of-scan pulse (pre-trigger), rising-edge sensitive |
| trigIn | input | 1 | Scan-clock trigger, rising-edge sensitive |
| convStrobe | output | 1 | Conversion strobe to the ADC |
| convSel | output | 1 | Channel select, 0 array, 1 reference |
| adcValid | input | 1 | ADC result valid |
| adcData | input | DATA_W | ADC result |
| pairValid | output | 1 | Saved pair valid, one cycle |
| pairArray | output | DATA_W | Array channel result |
| pairRef | output | DATA_W | Reference channel result |
| done | output | 1 | Scan count exhausted |
| overrun | output | 1 | Sticky trigger-overrun flag |

## Verification
The bench builds the block with an 8-bit scan count and 3-bit phase lengths. The 3-bit phase fields mean every phase value from 0 through 7 is reachable, including the zero-clamped case and the longest train that still fits between triggers. The small count width keeps runs of one to four saved pairs short while the zero-count arm stays a directed case. The converter model answers one cycle after each strobe edge, which is the tightest timing at which the shortest phases can still attribute results to the right channel.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_ST,
    S_DISCARD,
    S_SAVE,
    S_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HIGH,
    PH_LOW
  } chPhase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCount;
    logic abortPair;
    logic startPair;
    logic saveTag;
  } seqStrobes_t;

  // datapath -> control status
  typedef struct packed {
    logic stRise;
    logic eosRise;
    logic trigRise;
    logic countZero;
    logic loadZero;
    logic pairBusy;
  } seqStatus_t;

endpackage

// File: rtl/acq_chan_pulse.sv
module acq_chan_pulse
  import acq_seq_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            abort,
  input  logic [PH_W-1:0] phaseHigh,
  input  logic [PH_W-1:0] phaseLow,
  output logic            strobe,
  output logic            chanSel,
  output logic            active
);

  localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);

  chPhase_t        phase;
  logic [PH_W-1:0] downCnt;
  logic [PH_W-1:0] highLen;
  logic [PH_W-1:0] lowLen;
  logic [PH_W-1:0] highEff;
  logic [PH_W-1:0] lowEff;

  always_comb begin
    highEff = (phaseHigh == '0) ? PH_ONE : phaseHigh;
    lowEff  = (phaseLow  == '0) ? PH_ONE : phaseLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      downCnt <= '0;
      highLen <= PH_ONE;
      lowLen  <= PH_ONE;
      chanSel <= 1'b0;
    end else if (abort) begin
      phase   <= PH_IDLE;
      downCnt <= '0;
      chanSel <= 1'b0;
    end else if (start) begin
      phase   <= PH_HIGH;
      chanSel <= 1'b0;
      downCnt <= highEff - PH_ONE;
      highLen <= highEff;
      lowLen  <= lowEff;
    end else begin
      case (phase)
        PH_HIGH: begin
          if (downCnt != '0) downCnt <= downCnt - PH_ONE;
          else begin
            phase   <= PH_LOW;
            downCnt <= lowLen - PH_ONE;
          end
        end
        PH_LOW: begin
          if (downCnt != '0) downCnt <= downCnt - PH_ONE;
          else if (!chanSel) begin
            phase   <= PH_HIGH;
            chanSel <= 1'b1;
            downCnt <= highLen - PH_ONE;
          end else begin
            phase <= PH_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign strobe = (phase == PH_HIGH);
  assign active = (phase != PH_IDLE);

endmodule

// File: rtl/acq_seq_dp.sv
module acq_seq_dp
  import acq_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  output seqStatus_t        stat,
  input  logic [CNT_W-1:0]  scanCount,
  input  logic              stIn,
  input  logic              eosIn,
  input  logic              trigIn,
  input  logic              chanSel,
  input  logic              trainActive,
  input  logic              adcValid,
  input  logic [DATA_W-1:0] adcData,
  output logic              pairValid,
  output logic [DATA_W-1:0] pairArray,
  output logic [DATA_W-1:0] pairRef
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              stPrev, eosPrev, trigPrev;
  logic [CNT_W-1:0]  remain;
  logic [DATA_W-1:0] arrHold;   // single overwritten slot
  logic              gotArr, awaitRef, saveTagQ;
  logic              resultOk, pairFire;

  assign resultOk = adcValid && awaitRef && !strb.abortPair && !strb.startPair;
  assign pairFire = resultOk && chanSel && gotArr && saveTagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stPrev    <= 1'b0;
      eosPrev   <= 1'b0;
      trigPrev  <= 1'b0;
      remain    <= '0;
      arrHold   <= '0;
      gotArr    <= 1'b0;
      awaitRef  <= 1'b0;
      saveTagQ  <= 1'b0;
      pairValid <= 1'b0;
      pairArray <= '0;
      pairRef   <= '0;
    end else begin
      stPrev   <= stIn;
      eosPrev  <= eosIn;
      trigPrev <= trigIn;

      if (strb.loadCount) remain <= scanCount;
      else if (pairFire)  remain <= remain - CNT_ONE;

      if (strb.abortPair) begin
        gotArr   <= 1'b0;
        awaitRef <= 1'b0;
        saveTagQ <= 1'b0;
      end else if (strb.startPair) begin
        gotArr   <= 1'b0;
        awaitRef <= 1'b1;
        saveTagQ <= strb.saveTag;
      end else if (resultOk) begin
        if (!chanSel) begin
          arrHold <= adcData;
          gotArr  <= 1'b1;
        end else begin
          awaitRef <= 1'b0;
        end
      end

      pairValid <= pairFire;
      if (pairFire) begin
        pairArray <= arrHold;
        pairRef   <= adcData;
      end
    end
  end

  always_comb begin
    stat.stRise    = stIn && !stPrev;
    stat.eosRise   = eosIn && !eosPrev;
    stat.trigRise  = trigIn && !trigPrev;
    stat.countZero = (remain == '0);
    stat.loadZero  = (scanCount == '0);
    stat.pairBusy  = awaitRef || trainActive;
  end

endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
  import acq_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armReq,
  input  seqStatus_t  stat,
  output seqStrobes_t strb,
  output logic        done,
  output logic        overrun
);

  seqState_t state, nextState;
  logic      setOverrun;

  always_comb begin
    nextState  = state;
    strb       = '0;
    setOverrun = 1'b0;
    if (armReq) begin
      strb.loadCount = 1'b1;
      strb.abortPair = 1'b1;
      nextState      = stat.loadZero ? S_DONE : S_WAIT_ST;
    end else begin
      case (state)
        S_WAIT_ST: if (stat.stRise) nextState = S_DISCARD;
        S_DISCARD: begin
          if (stat.eosRise) nextState = S_SAVE;
          if (stat.trigRise) begin
            if (stat.pairBusy) setOverrun = 1'b1;
            else begin
              strb.startPair = 1'b1;
              strb.saveTag   = 1'b0;
            end
          end
        end
        S_SAVE: begin
          if (stat.countZero) begin
            if (!stat.pairBusy) nextState = S_DONE;
          end else if (stat.trigRise) begin
            if (stat.pairBusy) setOverrun = 1'b1;
            else begin
              strb.startPair = 1'b1;
              strb.saveTag   = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      overrun <= 1'b0;
    end else begin
      state <= nextState;
      if (armReq)          overrun <= 1'b0;
      else if (setOverrun) overrun <= 1'b1;
    end
  end

  assign done = (state == S_DONE);

endmodule

// File: rtl/acq_seq_top.sv
module acq_seq_top
  import acq_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PH_W   = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armReq,
  input  logic [CNT_W-1:0]  scanCount,
  input  logic [PH_W-1:0]   phaseHigh,
  input  logic [PH_W-1:0]   phaseLow,
  input  logic              stIn,
  input  logic              eosIn,
  input  logic              trigIn,
  output logic              convStrobe,
  output logic              convSel,
  input  logic              adcValid,
  input  logic [DATA_W-1:0] adcData,
  output logic              pairValid,
  output logic [DATA_W-1:0] pairArray,
  output logic [DATA_W-1:0] pairRef,
  output logic              done,
  output logic              overrun
);

  seqStrobes_t strb;
  seqStatus_t  stat;
  logic        trainActive;

  acq_seq_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .armReq  (armReq),
    .stat    (stat),
    .strb    (strb),
    .done    (done),
    .overrun (overrun)
  );

  acq_seq_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .stat        (stat),
    .scanCount   (scanCount),
    .stIn        (stIn),
    .eosIn       (eosIn),
    .trigIn      (trigIn),
    .chanSel     (convSel),
    .trainActive (trainActive),
    .adcValid    (adcValid),
    .adcData     (adcData),
    .pairValid   (pairValid),
    .pairArray   (pairArray),
    .pairRef     (pairRef)
  );

  acq_chan_pulse #(.PH_W(PH_W)) pulse_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (strb.startPair),
    .abort     (strb.abortPair),
    .phaseHigh (phaseHigh),
    .phaseLow  (phaseLow),
    .strobe    (convStrobe),
    .chanSel   (convSel),
    .active    (trainActive)
  );

endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             armReq,
  input logic [CNT_W-1:0] scanCount,
  input logic             stIn,
  input logic             eosIn,
  input logic             convStrobe,
  input logic             convSel,
  input logic             pairValid,
  input logic             done,
  input logic             overrun
);

  logic stSeen, eosSeen, stPrevC, eosPrevC, strobePrevC, lastRiseSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stSeen      <= 1'b0;
      eosSeen     <= 1'b0;
      stPrevC     <= 1'b0;
      eosPrevC    <= 1'b0;
      strobePrevC <= 1'b0;
      lastRiseSel <= 1'b0;
    end else begin
      stPrevC     <= stIn;
      eosPrevC    <= eosIn;
      strobePrevC <= convStrobe;
      if (convStrobe && !strobePrevC) lastRiseSel <= convSel;
      if (armReq) begin
        stSeen  <= 1'b0;
        eosSeen <= 1'b0;
      end else begin
        if (stIn && !stPrevC) stSeen <= 1'b1;
        if (stSeen && eosIn && !eosPrevC) eosSeen <= 1'b1;
      end
    end
  end

  p_arm_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    armReq |=> !overrun);

  p_conv_after_st_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStrobe) |-> stSeen);

  p_save_after_eos_r3: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> eosSeen);

  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    convStrobe && $past(convStrobe) |-> $stable(convSel));

  p_sel_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStrobe) && convSel |-> !lastRiseSel);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !convStrobe && !pairValid);

  p_zero_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    armReq && (scanCount == '0) |=> done);

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !armReq |=> overrun);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    armReq |=> !convStrobe);

endmodule

bind acq_seq_top acq_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .armReq     (armReq),
  .scanCount  (scanCount),
  .stIn       (stIn),
  .eosIn      (eosIn),
  .convStrobe (convStrobe),
  .convSel    (convSel),
  .pairValid  (pairValid),
  .done       (done),
  .overrun    (overrun)
);

// File: tb/acq_seq_top_tb_top.sv
`timescale 1ns/1ps
module acq_seq_top_tb_top;

  localparam int CNT_W  = 8;
  localparam int PH_W   = 3;
  localparam int DATA_W = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              armReq = 1'b0;
  logic [CNT_W-1:0]  scanCount = '0;
  logic [PH_W-1:0]   phaseHigh = PH_W'(1);
  logic [PH_W-1:0]   phaseLow = PH_W'(1);
  logic              stIn = 1'b0, eosIn = 1'b0, trigIn = 1'b0;
  logic              convStrobe, convSel;
  logic              adcValid = 1'b0;
  logic [DATA_W-1:0] adcData = '0;
  logic              pairValid;
  logic [DATA_W-1:0] pairArray, pairRef;
  logic              done, overrun;

  always #2 clk = ~clk;

  acq_seq_top #(.CNT_W(CNT_W), .PH_W(PH_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .armReq(armReq), .scanCount(scanCount),
    .phaseHigh(phaseHigh), .phaseLow(phaseLow), .stIn(stIn), .eosIn(eosIn),
    .trigIn(trigIn), .convStrobe(convStrobe), .convSel(convSel),
    .adcValid(adcValid), .adcData(adcData), .pairValid(pairValid),
    .pairArray(pairArray), .pairRef(pairRef), .done(done), .overrun(overrun)
  );

  int checks = 0;
  int errors = 0;
  int riseCnt = 0;
  int outCnt = 0;
  int salt = 0;
  bit widthChk = 1'b1;
  int expHigh = 1, expLow = 1;
  int highRun = 0, lowRun = 0;
  bit lowMeasure = 1'b0;
  bit adcPend = 1'b0;
  int pendIdx = 0;
  bit strobePrev = 1'b0;
  logic         selLog [0:1023];
  logic [11:0]  outArr [0:255];
  logic [11:0]  outRefV[0:255];

  function automatic logic [11:0] convVal(input int idx);
    return 12'((idx * 1103 + salt) & 32'hFFF);
  endfunction

  function automatic int clampLen(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // ADC model and output monitor, all at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (adcPend) begin
        adcValid = 1'b1;
        adcData  = convVal(pendIdx);
        adcPend  = 1'b0;
      end else begin
        adcValid = 1'b0;
      end
      if (convStrobe && !strobePrev) begin
        if (lowMeasure && widthChk)
          check(lowRun == expLow, "R5 low phase", lowRun, expLow);
        lowMeasure = 1'b0;
        if (riseCnt < 1024) selLog[riseCnt] = convSel;
        pendIdx = riseCnt;
        adcPend = 1'b1;
        riseCnt++;
        highRun = 1;
      end else if (convStrobe) begin
        highRun++;
      end else if (strobePrev) begin
        if (widthChk) check(highRun == expHigh, "R5 high phase", highRun, expHigh);
        lowMeasure = !convSel;
        lowRun = 1;
      end else begin
        lowRun++;
      end
      if (pairValid) begin
        if (outCnt < 256) begin
          outArr[outCnt]  = pairArray;
          outRefV[outCnt] = pairRef;
        end
        outCnt++;
      end
      strobePrev = convStrobe;
    end
  end

  task automatic arm(input int cnt, input int ph, input int pl);
    @(negedge clk);
    phaseHigh = PH_W'(ph);
    phaseLow  = PH_W'(pl);
    expHigh   = clampLen(ph);
    expLow    = clampLen(pl);
    scanCount = CNT_W'(cnt);
    armReq    = 1'b1;
    @(negedge clk);
    armReq = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: stIn = 1'b1;
      1: eosIn = 1'b1;
      default: trigIn = 1'b1;
    endcase
    @(negedge clk);
    stIn = 1'b0; eosIn = 1'b0; trigIn = 1'b0;
  endtask

  // trigger expected to run a full pair; returns the index of its first strobe
  task automatic trigPair(input string tag, output int base);
    int r0;
    r0 = riseCnt;
    base = r0;
    pulse(2);
    repeat (36) @(negedge clk);
    check(riseCnt - r0 == 2, {tag, " R4 two strobes"}, riseCnt - r0, 2);
    if (riseCnt - r0 == 2) begin
      check(selLog[r0] == 1'b0, "R4 first select", int'(selLog[r0]), 0);
      check(selLog[r0+1] == 1'b1, "R4 second select", int'(selLog[r0+1]), 1);
    end
  endtask

  task automatic runScan(input int nDisc, input int nSave, input int ph, input int pl);
    int base, o0, r0;
    int bases[8];
    arm(nSave, ph, pl);
    check(overrun == 1'b0, "R1 overrun cleared", int'(overrun), 0);
    r0 = riseCnt;
    pulse(2);
    pulse(1);
    repeat (6) @(negedge clk);
    check(riseCnt == r0, "R1 no conversion before start", riseCnt - r0, 0);
    pulse(0);
    o0 = outCnt;
    for (int i = 0; i < nDisc; i++) begin
      trigPair("R2", base);
      check(outCnt == o0, "R2 discarded pair not output", outCnt - o0, 0);
    end
    pulse(1);
    for (int i = 0; i < nSave; i++) begin
      trigPair("R3", base);
      bases[i] = base;
    end
    check(outCnt - o0 == nSave, "R6 saved pair count", outCnt - o0, nSave);
    for (int i = 0; i < nSave; i++) begin
      if (o0 + i < outCnt) begin
        check(outArr[o0+i] == convVal(bases[i]), "R6 array value",
              int'(outArr[o0+i]), int'(convVal(bases[i])));
        check(outRefV[o0+i] == convVal(bases[i]+1), "R6 reference value",
              int'(outRefV[o0+i]), int'(convVal(bases[i]+1)));
      end
    end
    check(done == 1'b1, "R7 done after count", int'(done), 1);
    r0 = riseCnt;
    pulse(2);
    repeat (20) @(negedge clk);
    check(riseCnt == r0, "R7 trigger ignored when done", riseCnt - r0, 0);
    check(outCnt - o0 == nSave, "R7 no extra output", outCnt - o0, nSave);
    check(overrun == 1'b0, "R9 no overrun on spaced triggers", int'(overrun), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    finishRun();
  end

  initial begin
    int base, r0, o0;
    void'($urandom(32'd2718));
    salt = int'($urandom_range(0, 4095));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(overrun == 1'b0, "R9 reset overrun", int'(overrun), 0);
    check(convStrobe == 1'b0, "R4 reset strobe", int'(convStrobe), 0);
    check(pairValid == 1'b0, "R6 reset valid", int'(pairValid), 0);

    // directed: shortest phases, zero phases (clamped), longest phases
    runScan(1, 2, 1, 1);
    runScan(0, 1, 0, 0);
    runScan(2, 3, 7, 7);

    // random mix
    for (int it = 0; it < 8; it++) begin
      runScan(int'($urandom_range(0, 2)), int'($urandom_range(1, 4)),
              int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
    end

    // R3: end-of-scan before start is ignored, first EOS after start counts
    arm(1, 2, 2);
    pulse(1);
    pulse(0);
    o0 = outCnt;
    trigPair("R3 early eos", base);
    check(outCnt == o0, "R3 eos before start ignored", outCnt - o0, 0);
    pulse(1);
    trigPair("R3 late eos", base);
    check(outCnt - o0 == 1, "R3 saving after eos", outCnt - o0, 1);

    // R8: zero scan count
    arm(0, 1, 1);
    check(done == 1'b1, "R8 done after zero arm", int'(done), 1);
    r0 = riseCnt;
    pulse(0); pulse(1); pulse(2);
    repeat (20) @(negedge clk);
    check(riseCnt == r0, "R8 no strobes when done", riseCnt - r0, 0);

    // R9: trigger during a pair
    arm(3, 3, 3);
    pulse(0); pulse(1);
    r0 = riseCnt; o0 = outCnt;
    pulse(2);
    repeat (2) @(negedge clk);
    pulse(2);
    repeat (36) @(negedge clk);
    check(overrun == 1'b1, "R9 overrun set", int'(overrun), 1);
    check(riseCnt - r0 == 2, "R9 no extra strobe", riseCnt - r0, 2);
    check(outCnt - o0 == 1, "R9 first pair kept", outCnt - o0, 1);
    trigPair("R9 after overrun", base);
    check(overrun == 1'b1, "R9 overrun sticky", int'(overrun), 1);
    arm(2, 3, 3);
    check(overrun == 1'b0, "R1 arm clears overrun", int'(overrun), 0);

    // R10: arm aborts a pair in flight
    pulse(0); pulse(1);
    widthChk = 1'b0;
    r0 = riseCnt; o0 = outCnt;
    pulse(2);
    @(negedge clk);
    arm(2, 3, 3);
    check(convStrobe == 1'b0, "R10 strobe low after arm", int'(convStrobe), 0);
    repeat (36) @(negedge clk);
    check(riseCnt - r0 == 1, "R10 pair abandoned", riseCnt - r0, 1);
    check(outCnt == o0, "R10 no output", outCnt - o0, 0);
    check(done == 1'b0, "R10 not done", int'(done), 0);

    finishRun();
  end

endmodule